// File: doc/BRIEF.md
# Dual Chroma-Key Video Fader

This block mixes two streams of Y/U/V pixels on a per-sample basis. One stream carries the main video. The other is a secondary decoded picture, and it serves as the key source. Each secondary sample is compared against two programmable colour windows. A window is a box bounded above and below on every component.

When the first window contains the sample, the output is a weighted mix of the main video and the secondary sample. When only the second window contains it, the output mixes the main video with a fixed programmable lookup colour instead. When neither window matches, the main video leaves the block unchanged. Each window has its own 6-bit weight, where 0 selects the non-video source entirely and 63 selects the video entirely.

A byte-wide write port sets the window limits, the two weights, the lookup colour and a pair of format bits. The format bits state whether each input stream is two's complement or straight binary. Results appear two clock cycles after a sample is presented, and a delayed copy of the input strobe marks them.

Top module: `ckey_fader`

## Requirements
- R1: Reset behaviour. During reset and after it, `validOut` and all outputs are 0. The reset state of the configuration is:
  - every limit is 0x80;
  - both weights are 63;
  - the lookup colour is Y=0x10, U=0x80, V=0x80;
  - both inputs are straight binary.
- R2: Window 1 matches when each secondary component c satisfies lo(c) <= c <= hi(c), with both bounds inclusive. The limits sit at addresses 0..5 in the order Ylo, Yhi, Ulo, Uhi, Vlo, Vhi. Window 2 uses the same order at addresses 6..11.
- R3: On a window-1 match, each output component equals (f1*video + (63-f1)*secondary + 31)/63, using integer division. f1 is written at address 12.
- R4: On a window-2 match without a window-1 match, each output component equals (f2*video + (63-f2)*lookup + 31)/63. f2 is written at address 13. The lookup Y, U and V are written at addresses 14, 15 and 16.
- R5: When both windows match, window 1 decides the result.
- R6: When neither window matches, the output equals the video sample, converted to straight binary.
- R7: A weight of 0 outputs the non-video source exactly, and a weight of 63 outputs the video exactly.
- R8: Address 17 holds the format bits: bit 0 applies to the video input and bit 1 to the secondary input. A value of 1 means straight binary and 0 means two's complement. Two's complement is converted by inverting the MSB before comparison and mixing. The outputs are always straight binary.
- R9: Bits 7:6 of a weight write are ignored, and only bits 5:0 are stored.
- R10: `validOut` equals `validIn` from two cycles earlier. The outputs carry the result for that sample, and back-to-back samples are accepted.
- R11: A register write takes effect from the next cycle. A sample presented in the same cycle as a write uses the configuration held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register address |
| wrData | input | 8 | Register write data |
| validIn | input | 1 | Input sample strobe |
| vidY | input | 8 | Video luma |
| vidU | input | 8 | Video U chroma |
| vidV | input | 8 | Video V chroma |
| secY | input | 8 | Secondary luma |
| secU | input | 8 | Secondary U chroma |
| secV | input | 8 | Secondary V chroma |
| validOut | output | 1 | Output sample strobe |
| outY | output | 8 | Mixed luma |
| outU | output | 8 | Mixed U chroma |
| outV | output | 8 | Mixed V chroma |

## Verification
Two events can land in the same cycle. The first is a match in both key windows. The bench provokes it by widening window 2 until it covers all of window 1, then checks that the result follows the window-1 weight and the secondary sample rather than the lookup colour. The second is a register write that arrives together with a sample. The bench raises `wrEn` and `validIn` on the same edge and expects the old weight for that sample and the new weight for the sample after it.

// File: rtl/ckey_pkg.sv
package ckey_pkg;
  localparam int PIX_W   = 8;
  localparam int FADE_W  = 6;
  localparam int ADDR_W  = 5;
  localparam int NKEY    = 2;
  localparam int NCOMP   = 3;
  localparam int LIM_PER_KEY = 2 * NCOMP;
  localparam int NLIM    = NKEY * LIM_PER_KEY;

  localparam int ADDR_LIM0  = 0;
  localparam int ADDR_FADE0 = ADDR_LIM0 + NLIM;
  localparam int ADDR_LUT0  = ADDR_FADE0 + NKEY;
  localparam int ADDR_FMT   = ADDR_LUT0 + NCOMP;

  localparam logic [PIX_W-1:0]  LIM_RST  = 8'h80;
  localparam logic [FADE_W-1:0] FADE_RST = '1;

  typedef logic [PIX_W-1:0] pix_t;

  typedef struct packed {
    pix_t y;
    pix_t u;
    pix_t v;
  } yuv_t;

  typedef struct packed {
    yuv_t lo;
    yuv_t hi;
    logic [FADE_W-1:0] fade;
  } key_t;

  // Configuration strobes handed from control to datapath
  typedef struct packed {
    key_t [NKEY-1:0] keys;
    yuv_t lut;
    logic vidBin;
    logic secBin;
  } cfg_t;

  function automatic yuv_t toBinary(yuv_t x, logic isBin);
    yuv_t r;
    r = x;
    if (!isBin) begin
      r.y[PIX_W-1] = ~x.y[PIX_W-1];
      r.u[PIX_W-1] = ~x.u[PIX_W-1];
      r.v[PIX_W-1] = ~x.v[PIX_W-1];
    end
    return r;
  endfunction
endpackage

// File: rtl/ckey_regs.sv
module ckey_regs
  import ckey_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PIX_W-1:0]  wrData,
  output cfg_t              cfg
);
  pix_t              limReg  [NLIM];
  logic [FADE_W-1:0] fadeReg [NKEY];
  pix_t              lutReg  [NCOMP];
  logic [1:0]        fmtReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NLIM; i++) limReg[i] <= LIM_RST;
      for (int k = 0; k < NKEY; k++) fadeReg[k] <= FADE_RST;
      for (int c = 0; c < NCOMP; c++) lutReg[c] <= (c == 0) ? 8'h10 : 8'h80;
      fmtReg <= 2'b11;
    end else if (wrEn) begin
      for (int i = 0; i < NLIM; i++)
        if (wrAddr == ADDR_W'(ADDR_LIM0 + i)) limReg[i] <= wrData;
      for (int k = 0; k < NKEY; k++)
        if (wrAddr == ADDR_W'(ADDR_FADE0 + k)) fadeReg[k] <= wrData[FADE_W-1:0];
      for (int c = 0; c < NCOMP; c++)
        if (wrAddr == ADDR_W'(ADDR_LUT0 + c)) lutReg[c] <= wrData;
      if (wrAddr == ADDR_W'(ADDR_FMT)) fmtReg <= wrData[1:0];
    end
  end

  always_comb begin
    for (int k = 0; k < NKEY; k++) begin
      cfg.keys[k].lo   = {limReg[k*LIM_PER_KEY+0], limReg[k*LIM_PER_KEY+2], limReg[k*LIM_PER_KEY+4]};
      cfg.keys[k].hi   = {limReg[k*LIM_PER_KEY+1], limReg[k*LIM_PER_KEY+3], limReg[k*LIM_PER_KEY+5]};
      cfg.keys[k].fade = fadeReg[k];
    end
    cfg.lut    = {lutReg[0], lutReg[1], lutReg[2]};
    cfg.vidBin = fmtReg[0];
    cfg.secBin = fmtReg[1];
  end
endmodule

// File: rtl/ckey_window.sv
module ckey_window
  import ckey_pkg::*;
(
  input  yuv_t smp,
  input  yuv_t lo,
  input  yuv_t hi,
  output logic hit
);
  logic [NCOMP-1:0] inRange;

  for (genvar c = 0; c < NCOMP; c++) begin : g_cmp
    localparam int LSB = c * PIX_W;
    assign inRange[c] = (smp[LSB +: PIX_W] >= lo[LSB +: PIX_W]) &&
                        (smp[LSB +: PIX_W] <= hi[LSB +: PIX_W]);
  end

  assign hit = &inRange;
endmodule

// File: rtl/ckey_blend.sv
module ckey_blend
  import ckey_pkg::*;
(
  input  pix_t              a,
  input  pix_t              b,
  input  logic [FADE_W-1:0] f,
  output pix_t              q
);
  localparam int MAXF  = (1 << FADE_W) - 1;
  localparam int SUM_W = PIX_W + FADE_W + 1;

  logic [FADE_W-1:0] fInv;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  quo;

  always_comb begin
    fInv = ~f;
    sum  = SUM_W'(f) * SUM_W'(a) + SUM_W'(fInv) * SUM_W'(b) + SUM_W'(MAXF / 2);
    quo  = sum / SUM_W'(MAXF);
    q    = quo[PIX_W-1:0];
  end
endmodule

// File: rtl/ckey_mix.sv
module ckey_mix
  import ckey_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  cfg_t cfg,
  input  logic validIn,
  input  yuv_t vidRaw,
  input  yuv_t secRaw,
  output logic validOut,
  output yuv_t mixOut
);
  yuv_t vidS, secS;
  logic [NKEY-1:0] hit;

  yuv_t              othD, vidQ, othQ, mixD;
  logic [FADE_W-1:0] facD, facQ;
  logic              v1Q;

  assign vidS = toBinary(vidRaw, cfg.vidBin);
  assign secS = toBinary(secRaw, cfg.secBin);

  for (genvar k = 0; k < NKEY; k++) begin : g_key
    ckey_window u_win (
      .smp(secS),
      .lo (cfg.keys[k].lo),
      .hi (cfg.keys[k].hi),
      .hit(hit[k])
    );
  end

  // Window 0 wins; a miss blends with full weight on video
  always_comb begin
    if (hit[0]) begin
      facD = cfg.keys[0].fade;
      othD = secS;
    end else if (hit[1]) begin
      facD = cfg.keys[1].fade;
      othD = cfg.lut;
    end else begin
      facD = '1;
      othD = vidS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vidQ <= '0;
      othQ <= '0;
      facQ <= '0;
      v1Q  <= 1'b0;
    end else begin
      vidQ <= vidS;
      othQ <= othD;
      facQ <= facD;
      v1Q  <= validIn;
    end
  end

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    localparam int LSB = c * PIX_W;
    ckey_blend u_bl (
      .a(vidQ[LSB +: PIX_W]),
      .b(othQ[LSB +: PIX_W]),
      .f(facQ),
      .q(mixD[LSB +: PIX_W])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mixOut   <= '0;
      validOut <= 1'b0;
    end else begin
      mixOut   <= mixD;
      validOut <= v1Q;
    end
  end
endmodule

// File: rtl/ckey_fader.sv
module ckey_fader
  import ckey_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PIX_W-1:0]  wrData,
  input  logic              validIn,
  input  logic [PIX_W-1:0]  vidY,
  input  logic [PIX_W-1:0]  vidU,
  input  logic [PIX_W-1:0]  vidV,
  input  logic [PIX_W-1:0]  secY,
  input  logic [PIX_W-1:0]  secU,
  input  logic [PIX_W-1:0]  secV,
  output logic              validOut,
  output logic [PIX_W-1:0]  outY,
  output logic [PIX_W-1:0]  outU,
  output logic [PIX_W-1:0]  outV
);
  cfg_t cfg;
  yuv_t mixOut;

  ckey_regs u_regs (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .cfg   (cfg)
  );

  ckey_mix u_mix (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfg),
    .validIn (validIn),
    .vidRaw  ({vidY, vidU, vidV}),
    .secRaw  ({secY, secU, secV}),
    .validOut(validOut),
    .mixOut  (mixOut)
  );

  assign outY = mixOut.y;
  assign outU = mixOut.u;
  assign outV = mixOut.v;
endmodule

// File: rtl/ckey_fader_chk.sv
module ckey_fader_chk
  import ckey_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [PIX_W-1:0]  wrData,
  input logic              validIn,
  input logic              validOut,
  input cfg_t              cfg
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !validOut);

  // R10
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (validOut == $past(validIn, 2)));

  // R9
  fade_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(ADDR_FADE0)) |=> (cfg.keys[0].fade == $past(wrData[FADE_W-1:0])));

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(cfg));
endmodule

bind ckey_fader ckey_fader_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .validIn (validIn),
  .validOut(validOut),
  .cfg     (cfg)
);

// File: tb/sim_ckey_fader.sv
`timescale 1ns/1ps
module sim_ckey_fader;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       validIn = 1'b0;
  logic [7:0] vidY = '0, vidU = '0, vidV = '0;
  logic [7:0] secY = '0, secU = '0, secV = '0;
  logic       validOut;
  logic [7:0] outY, outU, outV;

  int checks = 0;
  int errors = 0;

  int lim [12];
  int fade [2];
  int lut [3];
  int fmt;

  always #2 clk = ~clk;

  ckey_fader u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .validIn(validIn), .vidY(vidY), .vidU(vidU), .vidV(vidV),
    .secY(secY), .secU(secU), .secV(secV),
    .validOut(validOut), .outY(outY), .outU(outU), .outV(outV)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cv(int x, int isBin);
    return isBin != 0 ? x : (x ^ 128);
  endfunction

  function automatic int mixv(int f, int a, int b);
    return (f * a + (63 - f) * b + 31) / 63;
  endfunction

  function automatic void model(input int v[3], input int s[3], output int e[3]);
    int vs[3];
    int ss[3];
    bit h1, h2;
    h1 = 1; h2 = 1;
    for (int c = 0; c < 3; c++) begin
      vs[c] = cv(v[c], fmt & 1);
      ss[c] = cv(s[c], (fmt >> 1) & 1);
      if (ss[c] < lim[2*c] || ss[c] > lim[2*c+1]) h1 = 0;
      if (ss[c] < lim[6+2*c] || ss[c] > lim[6+2*c+1]) h2 = 0;
    end
    for (int c = 0; c < 3; c++) begin
      if (h1)      e[c] = mixv(fade[0], vs[c], ss[c]);
      else if (h2) e[c] = mixv(fade[1], vs[c], lut[c]);
      else         e[c] = vs[c];
    end
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
    if (a < 12) lim[a] = d;
    else if (a < 14) fade[a-12] = d & 63;
    else if (a < 17) lut[a-14] = d;
    else fmt = d & 3;
  endtask

  task automatic drive(int v[3], int s[3], bit vld);
    vidY = 8'(v[0]); vidU = 8'(v[1]); vidV = 8'(v[2]);
    secY = 8'(s[0]); secU = 8'(s[1]); secV = 8'(s[2]);
    validIn = vld;
  endtask

  task automatic pixExp(int v[3], int s[3], int e[3], string req);
    @(negedge clk);
    drive(v, s, 1'b1);
    @(negedge clk);
    validIn = 1'b0;
    @(negedge clk);
    check(req, int'(validOut), 1);
    check(req, int'(outY), e[0]);
    check(req, int'(outU), e[1]);
    check(req, int'(outV), e[2]);
  endtask

  task automatic pix(int v[3], int s[3], string req);
    int e[3];
    model(v, s, e);
    pixExp(v, s, e, req);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v[3], s[3], e[3];
    for (int i = 0; i < 12; i++) lim[i] = 128;
    fade[0] = 63; fade[1] = 63;
    lut[0] = 16; lut[1] = 128; lut[2] = 128;
    fmt = 3;

    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    check("R1", int'(validOut), 0);
    check("R1", int'(outY) + int'(outU) + int'(outV), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(validOut), 0);

    // R1: defaults, 0x80 sample hits window 1 at weight 63, straight binary
    v = '{0, 5, 250}; s = '{128, 128, 128};
    pixExp(v, s, '{0, 5, 250}, "R1");
    s = '{127, 128, 128};
    pixExp(v, s, '{0, 5, 250}, "R1");

    // Program both windows, weights and lookup
    wr(0, 40);  wr(1, 60);  wr(2, 70);  wr(3, 90);  wr(4, 100); wr(5, 120);
    wr(6, 150); wr(7, 200); wr(8, 150); wr(9, 200); wr(10, 150); wr(11, 200);
    wr(12, 20); wr(13, 40);
    wr(14, 8'hE0); wr(15, 8'h20); wr(16, 8'h90);

    // R2 R6: sweep each component across window 1
    v = '{200, 50, 10};
    for (int x = 0; x < 256; x++) begin s = '{x, 80, 110};  pix(v, s, "R2"); end
    for (int x = 0; x < 256; x++) begin s = '{50, x, 110};  pix(v, s, "R2"); end
    for (int x = 0; x < 256; x++) begin s = '{50, 80, x};   pix(v, s, "R6"); end
    // R4: sweep across window 2
    for (int x = 0; x < 256; x++) begin s = '{x, 170, 170}; pix(v, s, "R4"); end

    // R3 R7: weight 1 sweep
    for (int f = 0; f < 64; f++) begin
      wr(12, f);
      v = '{f * 4, 255 - f, 33}; s = '{45, 75, 115};
      pix(v, s, "R3");
    end
    pixExp('{9, 8, 7}, '{45, 75, 115}, '{9, 8, 7}, "R7");
    wr(12, 0);
    pixExp('{9, 8, 7}, '{45, 75, 115}, '{45, 75, 115}, "R7");

    // R4 R7: weight 2 sweep toward lookup
    for (int f = 0; f < 64; f++) begin
      wr(13, f);
      v = '{3 * f, 100, 255 - 2 * f}; s = '{160, 190, 155};
      pix(v, s, "R4");
    end
    wr(13, 0);
    pixExp('{1, 2, 3}, '{160, 190, 155}, '{8'hE0, 8'h20, 8'h90}, "R7");

    // R5: window 2 covers window 1, window 1 must win
    wr(6, 0); wr(7, 255); wr(8, 0); wr(9, 255); wr(10, 0); wr(11, 255);
    pixExp('{1, 2, 3}, '{50, 80, 110}, '{50, 80, 110}, "R5");
    wr(12, 31);
    pix('{240, 10, 77}, '{41, 89, 101}, "R5");

    // R9: reserved bits of a weight write
    wr(12, 8'hC5);
    pixExp('{200, 0, 63}, '{50, 80, 110},
           '{mixv(5, 200, 50), mixv(5, 0, 80), mixv(5, 63, 110)}, "R9");

    // R8: two's complement on both inputs
    wr(17, 0);
    pixExp('{0, 8'h7F, 8'h80}, '{50 ^ 128, 80 ^ 128, 110 ^ 128},
           '{mixv(5, 128, 50), mixv(5, 255, 80), mixv(5, 0, 110)}, "R8");
    wr(6, 200); wr(7, 201);
    pixExp('{0, 8'hFF, 8'h01}, '{0, 0, 0}, '{128, 127, 129}, "R8");
    v = '{17, 200, 90};
    for (int x = 0; x < 256; x++) begin s = '{x, 80 ^ 128, 110 ^ 128}; pix(v, s, "R8"); end
    wr(17, 3);

    // R11: write and sample in the same cycle
    wr(12, 63);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd12; wrData = 8'd0;
    drive('{10, 20, 30}, '{50, 80, 110}, 1'b1);
    @(negedge clk);
    wrEn = 1'b0;
    fade[0] = 0;
    drive('{10, 20, 30}, '{51, 81, 111}, 1'b1);
    @(negedge clk);
    validIn = 1'b0;
    check("R11", int'(outY), 10);
    check("R11", int'(outV), 30);
    @(negedge clk);
    check("R11", int'(outY), 51);
    check("R11", int'(outU), 81);

    // R10: back-to-back and gapped samples
    begin
      bit pat[10] = '{1, 1, 0, 1, 1, 1, 0, 0, 1, 0};
      int exY[10];
      wr(12, 25);
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (i >= 2) begin
          check("R10", int'(validOut), int'(pat[i-2]));
          if (pat[i-2]) check("R10", int'(outY), exY[i-2]);
        end
        if (i < 10) begin
          v = '{i * 20, 5, 6}; s = '{42 + i, 80, 110};
          model(v, s, e);
          exY[i] = e[0];
          drive(v, s, pat[i]);
        end else begin
          validIn = 1'b0;
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule